// File: doc/BRIEF.md
# Fully Associative Address Translation Cache with Address-Space Tags

This block translates a 32-bit virtual address into a 32-bit physical address within the same cycle. Its 64 entries are all searched in parallel. Each entry is tagged with a 6-bit address-space identifier, so the cache can hold translations for several processes at once and a context switch needs no flush. The three top address bits select a segment. Two kernel physical windows skip the search and are mapped directly, one cacheable and one uncached. The user segment and the kernel virtual segment are translated through the entries.

A lookup ends in one of three ways. It is a hit with a physical address and a cacheable attribute. It is a miss, left to external handling code. Or it is a modify exception, raised when a store reaches a clean page. The handling code installs entries through a write port, either at an explicit slot or at a slot the block picks: the lowest free slot, or the least recently used one when every slot is valid. A flush input drops every entry at once. Walking page tables is left to the surrounding system.

Top module: `xlat_cache`

## Requirements
- R1: When `lk_vaddr[31]` is 0 (user segment), an entry matches if it is valid, its page tag equals `lk_vaddr[31:12]` and its identifier equals `lk_asid`. A matching entry gives `lk_hit`=1, `lk_paddr` = {entry frame, `lk_vaddr[11:0]`}, and `lk_cached` = the entry's cacheable bit.
- R2: In the user segment the entry's global bit is ignored. An entry with a different identifier gives `lk_miss`=1 even when its global bit is set.
- R3: When `lk_vaddr[31:30]` is 2'b11 (kernel virtual), an entry matches if its page tag is equal and either its global bit is set or its identifier equals `lk_asid`.
- R4: When `lk_vaddr[31:29]` is 3'b100 or 3'b101, the entries are not consulted, even if one has a matching tag. The result is `lk_hit`=1 and `lk_paddr` = {3'b000, `lk_vaddr[28:0]`}. `lk_cached` is 1 for 3'b100 and 0 for 3'b101.
- R5: A lookup with `lk_store`=1 that matches an entry whose dirty bit is 0 gives `lk_modexc`=1 and `lk_hit`=0. If the entry's dirty bit is 1, the lookup gives a normal hit.
- R6: While `lk_valid`=1, exactly one of `lk_hit`, `lk_miss` and `lk_modexc` is 1. While `lk_valid`=0, all three are 0, and so are `lk_paddr` and `lk_cached`.
- R7: A write with `wr_en`=1 and `wr_use_idx`=1 installs the entry at slot `wr_idx` and marks it valid, replacing whatever that slot held.
- R8: A write with `wr_use_idx`=0 installs the entry at the lowest-numbered invalid slot.
- R9: A write with `wr_use_idx`=0 while all 64 slots are valid replaces the least recently used slot. Recency is updated by every write (at its slot) and by every lookup that ends in `lk_hit` through an entry. After reset, slot 0 is the most recent and slot 63 the least recent.
- R10: `flush`=1 clears every valid bit at the next clock edge. A write in the same cycle is discarded.
- R11: If several valid entries match, the lowest-numbered one supplies the result.
- R12: The result of a lookup appears combinationally in the same cycle its inputs are presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | A lookup is presented this cycle |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_asid | input | 6 | Identifier of the current address space |
| lk_store | input | 1 | The access is a store |
| wr_en | input | 1 | Install an entry at the next edge |
| wr_use_idx | input | 1 | 1: use wr_idx; 0: block chooses the slot |
| wr_idx | input | 6 | Explicit target slot |
| wr_vpn | input | 20 | Virtual page tag of the new entry |
| wr_asid | input | 6 | Identifier of the new entry |
| wr_pfn | input | 20 | Physical frame of the new entry |
| wr_dirty | input | 1 | Page may be written |
| wr_global | input | 1 | Matches any identifier in kernel virtual space |
| wr_cached | input | 1 | Cacheable attribute of the new entry |
| flush | input | 1 | Invalidate every entry |
| lk_hit | output | 1 | Successful translation |
| lk_miss | output | 1 | No entry matched in a translated segment |
| lk_modexc | output | 1 | Store to a page whose dirty bit is clear |
| lk_paddr | output | 32 | Physical address, valid with lk_hit |
| lk_cached | output | 1 | Cacheable attribute, valid with lk_hit |

## Verification
The assertions assume that reset is held for at least one edge, so that the recency ranks start out as a permutation of the slot numbers. They also assume that a lookup and a write never target the same cycle's recency update in conflicting ways: the write takes precedence and the lookup's touch is dropped. The stimulus never issues a lookup in the same cycle as a write or a flush. Every lookup is presented alone, with `lk_valid` dropped after its edge, so each recency update is unambiguous for the reference model. Writes use only the defined field encodings listed in the requirements.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    localparam int VA_W   = 32;
    localparam int OFF_W  = 12;
    localparam int VPN_W  = VA_W - OFF_W;
    localparam int PFN_W  = 20;
    localparam int PA_W   = PFN_W + OFF_W;
    localparam int ASID_W = 6;

    // Segment classes selected by the three top address bits
    typedef enum logic [1:0] {
        SEG_USER   = 2'd0,
        SEG_KPHY_C = 2'd1,
        SEG_KPHY_U = 2'd2,
        SEG_KVIRT  = 2'd3
    } seg_e;

    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic [PFN_W-1:0]  pfn;
        logic              dirty;
        logic              glob;
        logic              cached;
    } tlb_ent_t;

    typedef struct packed {
        logic             hit;
        logic             miss;
        logic             modexc;
        logic [PA_W-1:0]  paddr;
        logic             cached;
    } lk_res_t;

    function automatic seg_e seg_of(input logic [2:0] top);
        seg_e s;
        unique casez (top)
            3'b0??:  s = SEG_USER;
            3'b100:  s = SEG_KPHY_C;
            3'b101:  s = SEG_KPHY_U;
            default: s = SEG_KVIRT;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/xlat_seg_decode.sv
module xlat_seg_decode
    import xlat_pkg::*;
(
    input  logic [VA_W-1:0] vaddr,
    output seg_e            seg,
    output logic            bypass,
    output logic [PA_W-1:0] byp_paddr,
    output logic            byp_cached
);
    localparam int DIRECT_W = VA_W - 3;

    always_comb begin
        seg        = seg_of(vaddr[VA_W-1 -: 3]);
        bypass     = (seg == SEG_KPHY_C) || (seg == SEG_KPHY_U);
        byp_paddr  = PA_W'(vaddr[DIRECT_W-1:0]);
        byp_cached = (seg == SEG_KPHY_C);
    end

endmodule

// File: rtl/xlat_cam.sv
module xlat_cam
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               flush,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_slot,
    input  tlb_ent_t           wr_ent,
    input  logic [VPN_W-1:0]   lk_vpn,
    input  logic [ASID_W-1:0]  lk_asid,
    input  logic               lk_kvirt,
    output logic               hit_any,
    output logic [IDX_W-1:0]   hit_idx,
    output tlb_ent_t           hit_ent,
    output logic [ENTRIES-1:0] valid_vec
);
    tlb_ent_t           ent_q [ENTRIES];
    logic [ENTRIES-1:0] valid_q;
    logic [ENTRIES-1:0] match;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_slot] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && !flush) begin
            ent_q[wr_slot] <= wr_ent;
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = valid_q[g] && (ent_q[g].vpn == lk_vpn) &&
                          ((ent_q[g].asid == lk_asid) || (ent_q[g].glob && lk_kvirt));
    end

    // lowest index wins
    always_comb begin
        hit_any = 1'b0;
        hit_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit_any = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
        hit_ent = ent_q[hit_idx];
    end

    assign valid_vec = valid_q;

    // R10
    flush_clears_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (valid_q == '0));

    // R7
    wr_installs_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !flush) |=> valid_q[$past(wr_slot)]);

    // R11
    lowest_match_chk: assert property (@(posedge clk) disable iff (rst)
        hit_any |-> (match[hit_idx] &&
                     ((match & ((ENTRIES'(1) << hit_idx) - ENTRIES'(1))) == '0)));

endmodule

// File: rtl/xlat_lru.sv
module xlat_lru #(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               touch_en,
    input  logic [IDX_W-1:0]   touch_idx,
    input  logic [ENTRIES-1:0] valid_vec,
    output logic [IDX_W-1:0]   victim
);
    localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1);

    // rank 0 = most recent, ENTRIES-1 = least recent
    logic [IDX_W-1:0]   rank_q [ENTRIES];
    logic [ENTRIES-1:0] is_old;
    logic               any_free;
    logic [IDX_W-1:0]   free_idx;
    logic [IDX_W-1:0]   old_idx;

    always_ff @(posedge clk) begin
        for (int i = 0; i < ENTRIES; i++) begin
            if (rst) begin
                rank_q[i] <= IDX_W'(i);
            end else if (touch_en) begin
                if (IDX_W'(i) == touch_idx) begin
                    rank_q[i] <= '0;
                end else if (rank_q[i] < rank_q[touch_idx]) begin
                    rank_q[i] <= rank_q[i] + 1'b1;
                end
            end
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_old
        assign is_old[g] = (rank_q[g] == OLDEST);
    end

    always_comb begin
        any_free = 1'b0;
        free_idx = '0;
        old_idx  = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                any_free = 1'b1;
                free_idx = IDX_W'(i);
            end
            if (is_old[i]) begin
                old_idx = IDX_W'(i);
            end
        end
        victim = any_free ? free_idx : old_idx;
    end

    // R9
    single_oldest_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot(is_old));

    // R9
    touch_newest_chk: assert property (@(posedge clk) disable iff (rst)
        touch_en |=> (rank_q[$past(touch_idx)] == '0));

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              lk_store,
    input  logic              wr_en,
    input  logic              wr_use_idx,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic [PFN_W-1:0]  wr_pfn,
    input  logic              wr_dirty,
    input  logic              wr_global,
    input  logic              wr_cached,
    input  logic              flush,
    output logic              lk_hit,
    output logic              lk_miss,
    output logic              lk_modexc,
    output logic [PA_W-1:0]   lk_paddr,
    output logic              lk_cached
);
    seg_e               seg;
    logic               bypass;
    logic [PA_W-1:0]    byp_paddr;
    logic               byp_cached;
    logic               hit_any;
    logic [IDX_W-1:0]   hit_idx;
    tlb_ent_t           hit_ent;
    logic [ENTRIES-1:0] valid_vec;
    logic [IDX_W-1:0]   victim;
    logic [IDX_W-1:0]   wr_slot;
    tlb_ent_t           wr_ent;
    logic               touch_en;
    logic [IDX_W-1:0]   touch_idx;
    lk_res_t            res;

    xlat_seg_decode u_seg (
        .vaddr      (lk_vaddr),
        .seg        (seg),
        .bypass     (bypass),
        .byp_paddr  (byp_paddr),
        .byp_cached (byp_cached)
    );

    assign wr_slot = wr_use_idx ? wr_idx : victim;

    always_comb begin
        wr_ent.vpn    = wr_vpn;
        wr_ent.asid   = wr_asid;
        wr_ent.pfn    = wr_pfn;
        wr_ent.dirty  = wr_dirty;
        wr_ent.glob   = wr_global;
        wr_ent.cached = wr_cached;
    end

    xlat_cam #(.ENTRIES(ENTRIES)) u_cam (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .wr_en     (wr_en),
        .wr_slot   (wr_slot),
        .wr_ent    (wr_ent),
        .lk_vpn    (lk_vaddr[VA_W-1:OFF_W]),
        .lk_asid   (lk_asid),
        .lk_kvirt  (seg == SEG_KVIRT),
        .hit_any   (hit_any),
        .hit_idx   (hit_idx),
        .hit_ent   (hit_ent),
        .valid_vec (valid_vec)
    );

    always_comb begin
        res = '0;
        if (lk_valid) begin
            if (bypass) begin
                res.hit    = 1'b1;
                res.paddr  = byp_paddr;
                res.cached = byp_cached;
            end else if (!hit_any) begin
                res.miss = 1'b1;
            end else if (lk_store && !hit_ent.dirty) begin
                res.modexc = 1'b1;
            end else begin
                res.hit    = 1'b1;
                res.paddr  = {hit_ent.pfn, lk_vaddr[OFF_W-1:0]};
                res.cached = hit_ent.cached;
            end
        end
    end

    assign lk_hit    = res.hit;
    assign lk_miss   = res.miss;
    assign lk_modexc = res.modexc;
    assign lk_paddr  = res.paddr;
    assign lk_cached = res.cached;

    // recency: a write takes precedence over a lookup hit; flush suppresses both
    always_comb begin
        touch_en  = 1'b0;
        touch_idx = hit_idx;
        if (!flush) begin
            if (wr_en) begin
                touch_en  = 1'b1;
                touch_idx = wr_slot;
            end else if (res.hit && !bypass) begin
                touch_en = 1'b1;
            end
        end
    end

    xlat_lru #(.ENTRIES(ENTRIES)) u_lru (
        .clk       (clk),
        .rst       (rst),
        .touch_en  (touch_en),
        .touch_idx (touch_idx),
        .valid_vec (valid_vec),
        .victim    (victim)
    );

    // R6
    one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
        lk_valid |-> ($countones({lk_hit, lk_miss, lk_modexc}) == 1));

    // R6
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |-> (!lk_hit && !lk_miss && !lk_modexc && lk_paddr == '0));

    // R5
    modexc_store_chk: assert property (@(posedge clk) disable iff (rst)
        lk_modexc |-> lk_store);

    // R4
    kphys_direct_chk: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && lk_vaddr[VA_W-1 -: 2] == 2'b10) |->
        (lk_hit && lk_paddr == PA_W'(lk_vaddr[VA_W-4:0]) && lk_cached == !lk_vaddr[VA_W-3]));

endmodule

// File: tb/xlat_cache_tb.sv
module xlat_cache_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        lk_valid, lk_store;
    logic [31:0] lk_vaddr;
    logic [5:0]  lk_asid;
    logic        wr_en, wr_use_idx, wr_dirty, wr_global, wr_cached, flush;
    logic [5:0]  wr_idx, wr_asid;
    logic [19:0] wr_vpn, wr_pfn;
    logic        lk_hit, lk_miss, lk_modexc, lk_cached;
    logic [31:0] lk_paddr;

    int total = 0;
    int bad   = 0;

    // reference model state
    bit          m_valid [64];
    logic [19:0] m_vpn   [64];
    logic [5:0]  m_asid  [64];
    logic [19:0] m_pfn   [64];
    bit          m_dirty [64];
    bit          m_glob  [64];
    bit          m_cach  [64];
    int          lru_q [$];

    always #10 clk = ~clk;

    xlat_cache u_dut (
        .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .lk_asid(lk_asid), .lk_store(lk_store), .wr_en(wr_en),
        .wr_use_idx(wr_use_idx), .wr_idx(wr_idx), .wr_vpn(wr_vpn),
        .wr_asid(wr_asid), .wr_pfn(wr_pfn), .wr_dirty(wr_dirty),
        .wr_global(wr_global), .wr_cached(wr_cached), .flush(flush),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_modexc(lk_modexc),
        .lk_paddr(lk_paddr), .lk_cached(lk_cached)
    );

    function automatic void touch(int k);
        for (int i = 0; i < lru_q.size(); i++) begin
            if (lru_q[i] == k) begin
                lru_q.delete(i);
                break;
            end
        end
        lru_q.push_front(k);
    endfunction

    function automatic int pick_slot();
        for (int i = 0; i < 64; i++) if (!m_valid[i]) return i;
        return lru_q[lru_q.size() - 1];
    endfunction

    task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h (hit,miss,modexc,cached,paddr)", tag, act, exp);
        end
    endtask

    task automatic lookup(input logic [31:0] va, input logic [5:0] asid,
                          input bit st, input string tag);
        bit h, m, x, c, tch;
        logic [31:0] pa;
        int idx;
        @(negedge clk);
        lk_valid = 1'b1; lk_vaddr = va; lk_asid = asid; lk_store = st;
        #1;
        h = 0; m = 0; x = 0; c = 0; pa = '0; tch = 0; idx = -1;
        if (va[31:29] == 3'b100 || va[31:29] == 3'b101) begin
            h = 1; pa = {3'b000, va[28:0]}; c = (va[29] == 1'b0);
        end else begin
            for (int i = 0; i < 64; i++) begin
                if (m_valid[i] && m_vpn[i] == va[31:12] &&
                    (m_asid[i] == asid || (m_glob[i] && va[31:30] == 2'b11))) begin
                    idx = i;
                    break;
                end
            end
            if (idx < 0) m = 1;
            else if (st && !m_dirty[idx]) x = 1;
            else begin
                h = 1; pa = {m_pfn[idx], va[11:0]}; c = m_cach[idx]; tch = 1;
            end
        end
        check(tag, {lk_hit, lk_miss, lk_modexc, lk_cached, lk_paddr}, {h, m, x, c, pa});
        @(posedge clk);
        if (tch) touch(idx);
        #1 lk_valid = 1'b0; lk_store = 1'b0;
    endtask

    task automatic install(input bit use_idx, input int idx, input logic [19:0] vpn,
                           input logic [5:0] asid, input logic [19:0] pfn,
                           input bit d, input bit g, input bit c, input bit fl);
        int slot;
        @(negedge clk);
        wr_en = 1'b1; wr_use_idx = use_idx; wr_idx = 6'(idx); wr_vpn = vpn;
        wr_asid = asid; wr_pfn = pfn; wr_dirty = d; wr_global = g; wr_cached = c;
        flush = fl;
        slot = use_idx ? idx : pick_slot();
        @(posedge clk);
        if (fl) begin
            for (int i = 0; i < 64; i++) m_valid[i] = 0;
        end else begin
            m_valid[slot] = 1; m_vpn[slot] = vpn; m_asid[slot] = asid; m_pfn[slot] = pfn;
            m_dirty[slot] = d; m_glob[slot] = g; m_cach[slot] = c;
            touch(slot);
        end
        #1 wr_en = 1'b0; flush = 1'b0;
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(posedge clk);
        for (int i = 0; i < 64; i++) m_valid[i] = 0;
        #1 flush = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; lk_valid = 0; lk_vaddr = '0; lk_asid = '0; lk_store = 0;
        wr_en = 0; wr_use_idx = 0; wr_idx = '0; wr_vpn = '0; wr_asid = '0;
        wr_pfn = '0; wr_dirty = 0; wr_global = 0; wr_cached = 0; flush = 0;
        for (int i = 0; i < 64; i++) begin
            m_valid[i] = 0;
            lru_q.push_back(i);
        end
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R6 idle outputs after reset
        @(negedge clk); #1;
        check("R6 idle", {lk_hit, lk_miss, lk_modexc, lk_cached, lk_paddr}, 36'h0);

        lookup(32'h0001_2345, 6'd3, 0, "R6 R1 empty miss");
        lookup(32'h8123_4567, 6'd0, 0, "R4 cached window");
        lookup(32'hA765_4321, 6'd0, 0, "R4 uncached window");

        // R7 explicit slot installs
        install(1, 5, 20'h00012, 6'd3, 20'hABCDE, 1, 0, 1, 0);
        lookup(32'h0001_2345, 6'd3, 0, "R1 R12 user hit");
        lookup(32'h0001_2FFF, 6'd4, 0, "R1 other asid miss");
        install(1, 6, 20'h00034, 6'd1, 20'h11111, 0, 1, 0, 0);
        lookup(32'h0003_4010, 6'd2, 0, "R2 global ignored in user");
        lookup(32'h0003_4010, 6'd1, 0, "R1 clean page load hit");
        lookup(32'h0003_4010, 6'd1, 1, "R5 store to clean page");
        lookup(32'h0001_2000, 6'd3, 1, "R5 store to dirty page");
        install(1, 7, 20'hE0001, 6'd5, 20'h22222, 1, 1, 1, 0);
        lookup(32'hE000_1234, 6'd9, 0, "R3 global kernel virtual");
        install(1, 8, 20'hE0002, 6'd2, 20'h33333, 1, 0, 0, 0);
        lookup(32'hE000_2004, 6'd3, 0, "R3 nonglobal mismatch");
        lookup(32'hE000_2004, 6'd2, 0, "R3 nonglobal match");
        install(1, 9, 20'h80001, 6'd0, 20'h44444, 1, 1, 1, 0);
        lookup(32'h8000_1ABC, 6'd0, 0, "R4 entries not consulted");
        install(1, 20, 20'h00055, 6'd7, 20'h55555, 1, 0, 1, 0);
        install(1, 10, 20'h00055, 6'd7, 20'h66666, 1, 0, 0, 0);
        lookup(32'h0005_5008, 6'd7, 0, "R11 lowest index wins");
        install(1, 5, 20'h00077, 6'd3, 20'h77777, 1, 0, 1, 0);
        lookup(32'h0001_2345, 6'd3, 0, "R7 replaced slot old tag");
        lookup(32'h0007_7345, 6'd3, 0, "R7 replaced slot new tag");

        // R8 fill free slots lowest first
        for (int k = 0; k < 57; k++)
            install(0, 0, 20'h00100 + 20'(k), 6'd1, 20'h00100 + 20'(k), 1, 0, k[0], 0);
        for (int k = 0; k < 57; k++)
            lookup(32'h0010_0000 + (32'(k) << 12), 6'd1, 0, "R8 filled slots");

        // R9 replacement when full
        for (int k = 0; k < 4; k++)
            install(0, 0, 20'h00900 + 20'(k), 6'd1, 20'h00900 + 20'(k), 1, 0, 1, 0);
        for (int k = 0; k < 57; k++)
            lookup(32'h0010_0000 + (32'(k) << 12), 6'd1, 0, "R9 after eviction");
        for (int k = 0; k < 4; k++)
            lookup(32'h0090_0000 + (32'(k) << 12), 6'd1, 0, "R9 new entries");
        lookup(32'h0007_7000, 6'd3, 0, "R9 older entry");

        // R10 flush
        do_flush();
        lookup(32'h0090_0000, 6'd1, 0, "R10 flushed miss");
        lookup(32'hE000_1000, 6'd1, 0, "R10 flushed kernel miss");
        install(1, 3, 20'h00AAA, 6'd1, 20'h0AAAA, 1, 0, 1, 1);
        lookup(32'h00AA_A000, 6'd1, 0, "R10 write dropped by flush");

        // R8 after flush: lowest free slot is 0
        install(0, 0, 20'h00BBB, 6'd2, 20'h0BBBB, 1, 0, 1, 0);
        lookup(32'h00BB_B010, 6'd2, 0, "R8 first free slot");
        install(1, 0, 20'h00CCC, 6'd2, 20'h0CCCC, 1, 0, 0, 0);
        lookup(32'h00BB_B010, 6'd2, 0, "R8 slot zero overwritten");
        lookup(32'h00CC_C010, 6'd2, 0, "R8 R7 slot zero new");

        @(negedge clk); #1;
        check("R6 idle end", {lk_hit, lk_miss, lk_modexc, lk_cached, lk_paddr}, 36'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule